// File: doc/BRIEF.md
# Quarter-step fractional baud tick generator

This block derives the 16x oversampling strobe of an asynchronous serial port from the peripheral clock. Software programs a 32-bit divider word. A divider field D sits above six don't-care bits, and its least significant bit is worth a quarter of a clock period. Each oversample tick therefore spans (4 + D) / 4 clock periods. The serial bit rate is clk * 4 / (16 * (4 + D)). With a 15-bit field this covers clk/16 down to clk/(16 * 8192).

Fractional periods cannot be produced exactly by a clock-synchronous strobe. The block keeps a phase accumulator measured in quarter clocks instead. Each clock adds four quarters to it. Whenever the total reaches the period (4 + D), the block emits a tick and subtracts the period. Successive tick gaps then alternate between the two integers on either side of the ideal period, and the long-term rate is exact. Clearing the enable, or loading a different divider field, restarts the phase from zero. The tick output is a registered single-clock strobe.

Top module: `quarter_step_baud_gen`

## Requirements
- R1: Reset is synchronous and active high. In the cycle after a reset edge, `tick` is 0 and the phase starts again from zero.
- R2: Only bits 20:6 of `div_reg` form the divider field D, with bit 6 as its least significant bit. Bits 5:0 and bits 31:21 have no effect on `tick`, and changing them does not restart the phase.
- R3: With D = 0 and `en` high, `tick` is 1 after every clock edge except the edge that restarts the phase.
- R4: Count the N clock edges that follow a restart while `en` stays high and D stays constant. Exactly floor(4*N / (4 + D)) ticks appear over that span. The long-term rate is therefore 4 ticks per (4 + D) clocks.
- R5: Between consecutive ticks under a constant D, the gap in clocks is always floor((4+D)/4) or ceil((4+D)/4).
- R6: When D >= 4, `tick` is never high in two consecutive cycles.
- R7: While `en` is low, `tick` is 0 in the following cycle and the phase is cleared. After `en` rises, the first tick appears after ceil((4+D)/4) clock edges.
- R8: A clock edge at which the divider field differs from its value at the previous edge restarts the phase. `tick` is 0 in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| div_reg | input | 32 | Divider word; field D in bits 20:6 in quarter clocks, other bits ignored |
| en | input | 1 | Run enable; low holds the phase cleared and the tick low |
| tick | output | 1 | Registered 16x oversample strobe, one clock wide per tick |

## Verification
The hardest situation to reach is the sub-integer dithering of gaps near the extremes. Small fields such as D = 1 to 3 put back-to-back ticks next to skipped clocks. The largest field needs thousands of cycles before a second tick appears. The bench drives each of these fields from a fresh restart and counts the ticks over whole multiples of the period. It checks every inter-tick gap against the two allowed integers. It also changes the ignored divider bits on every clock during a counted window, to show that they never disturb the phase.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

  // Quarter-clock units added to the phase on every enabled clock.
  localparam int QSTEP = 4;

  // Position of the divider field inside the software word.
  localparam int FIELD_LSB = 6;

  typedef enum logic [1:0] {
    STEP_CLEAR = 2'd0,
    STEP_WAIT  = 2'd1,
    STEP_FIRE  = 2'd2
  } step_e;

endpackage

// File: rtl/baud_field_capture.sv
module baud_field_capture #(
  parameter int REG_W   = 32,
  parameter int FIELD_W = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [REG_W-1:0]   div_reg,
  output logic [FIELD_W-1:0] field_q,
  output logic               field_chg
);
  import baudgen_pkg::*;

  localparam int FIELD_HI = FIELD_LSB + FIELD_W;

  logic [FIELD_W-1:0] field_now;
  logic               unused_lo;
  logic               unused_hi;

  assign field_now = div_reg[FIELD_LSB +: FIELD_W];
  assign unused_lo = ^div_reg[FIELD_LSB-1:0];
  assign unused_hi = ^div_reg[REG_W-1:FIELD_HI];

  // A field change is judged against the value held from the previous edge.
  assign field_chg = (field_now != field_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      field_q <= '0;
    end else begin
      field_q <= field_now;
    end
  end

endmodule

// File: rtl/baud_phase_acc.sv
module baud_phase_acc #(
  parameter int FIELD_W = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               restart,
  input  logic [FIELD_W-1:0] field_q,
  output logic               tick_o
);
  import baudgen_pkg::*;

  // The phase stays below (4 + D); two spare bits absorb the +4 overshoot.
  localparam int ACC_W = FIELD_W + 2;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] period;
  logic [ACC_W-1:0] sum;
  step_e            step;

  assign period = ACC_W'(field_q) + ACC_W'(QSTEP);
  assign sum    = acc + ACC_W'(QSTEP);

  always_comb begin
    if (!en || restart) begin
      step = STEP_CLEAR;
    end else if (sum >= period) begin
      step = STEP_FIRE;
    end else begin
      step = STEP_WAIT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      tick_o <= 1'b0;
    end else begin
      unique case (step)
        STEP_CLEAR: begin
          acc    <= '0;
          tick_o <= 1'b0;
        end
        STEP_FIRE: begin
          acc    <= sum - period;
          tick_o <= 1'b1;
        end
        default: begin
          acc    <= sum;
          tick_o <= 1'b0;
        end
      endcase
    end
  end

  // The phase residue never reaches a full period, or ticks would be lost.
  assert_phase_bound_R4: assert property (@(posedge clk) disable iff (rst)
    acc < period)
    else $error("phase residue reached the period");

  assert_idle_low_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> !tick_o)
    else $error("tick while disabled");

  assert_restart_low_R8: assert property (@(posedge clk) disable iff (rst)
    restart |=> !tick_o)
    else $error("tick right after divider change");

endmodule

// File: rtl/quarter_step_baud_gen.sv
module quarter_step_baud_gen #(
  parameter int REG_W   = 32,
  parameter int FIELD_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] div_reg,
  input  logic             en,
  output logic             tick
);

  logic [FIELD_W-1:0] field_q;
  logic               field_chg;

  baud_field_capture #(
    .REG_W  (REG_W),
    .FIELD_W(FIELD_W)
  ) u_capture (
    .clk      (clk),
    .rst      (rst),
    .div_reg  (div_reg),
    .field_q  (field_q),
    .field_chg(field_chg)
  );

  baud_phase_acc #(
    .FIELD_W(FIELD_W)
  ) u_phase (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .restart(field_chg),
    .field_q(field_q),
    .tick_o (tick)
  );

  assert_full_rate_R3: assert property (@(posedge clk) disable iff (rst)
    (en && !field_chg && field_q == '0) |=> tick)
    else $error("zero divider did not tick every clock");

  assert_no_double_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && field_q >= FIELD_W'(4)) |=> !tick)
    else $error("back-to-back ticks with divider of at least one clock");

endmodule

// File: tb/test_quarter_step_baud_gen.sv
module test_quarter_step_baud_gen;

  localparam int REG_W   = 32;
  localparam int FIELD_W = 15;
  localparam int FMASK   = (1 << FIELD_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [REG_W-1:0] div_reg = '0;
  logic             en = 1'b0;
  logic             tick;

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R1";

  // Behavioural reference: quarter-clock phase kept as plain integers.
  int m_acc = 0;
  int m_fq  = 0;
  int m_exp = 0;

  always #4 clk = ~clk;

  quarter_step_baud_gen #(.REG_W(REG_W), .FIELD_W(FIELD_W)) i_quarter_step_baud_gen (
    .clk(clk), .rst(rst), .div_reg(div_reg), .en(en), .tick(tick)
  );

  always @(posedge clk) begin
    int f;
    int s;
    f = int'((div_reg >> 6) & FMASK);
    if (rst) begin
      m_acc = 0; m_fq = 0; m_exp = 0;
    end else begin
      if (!en || f != m_fq) begin
        m_acc = 0; m_exp = 0;
      end else begin
        s = m_acc + 4;
        if (s >= m_fq + 4) begin
          m_exp = 1; m_acc = s - m_fq - 4;
        end else begin
          m_exp = 0; m_acc = s;
        end
      end
      m_fq = f;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison with the reference model.
  always @(negedge clk) begin
    check(tick === m_exp[0], cur_req, int'(tick), m_exp);
  end

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Load a new field; the next edge restarts the phase (R8).
  task automatic apply_field(input int f);
    div_reg = REG_W'(f) << 6;
    cycle();
    check(tick === 1'b0, "R8", int'(tick), 0);
  endtask

  task automatic count_ticks(input int n, input int exp, input string req);
    int cnt = 0;
    for (int i = 0; i < n; i++) begin
      cycle();
      if (tick) cnt++;
    end
    check(cnt == exp, req, cnt, exp);
  endtask

  task automatic check_spacing(input int n, input int lo, input int hi, input string req);
    int gap = 0;
    bit seen = 0;
    int bad = 0;
    int badgap = 0;
    for (int i = 0; i < n; i++) begin
      cycle();
      gap++;
      if (tick) begin
        if (seen && (gap < lo || gap > hi)) begin
          bad++; badgap = gap;
        end
        seen = 1; gap = 0;
      end
    end
    check(bad == 0 && seen, req, badgap, lo);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(tick === 1'b0, "R1", int'(tick), 0);
    rst = 1'b0;
    cycle();
    check(tick === 1'b0, "R1", int'(tick), 0);

    cur_req = "R3";
    en = 1'b1;
    count_ticks(20, 20, "R3");

    cur_req = "R4";
    apply_field(1);  count_ticks(50, 40, "R4");
    apply_field(6);  count_ticks(100, 40, "R4");
    apply_field(13); count_ticks(170, 40, "R4");

    cur_req = "R5";
    apply_field(2); check_spacing(60, 1, 2, "R5");
    apply_field(3); check_spacing(70, 1, 2, "R5");
    cur_req = "R6";
    apply_field(9); check_spacing(130, 3, 4, "R5 R6");

    // Ignored bits toggled every clock while field 6 stays fixed (R2).
    cur_req = "R2";
    apply_field(6);
    begin
      int cnt = 0;
      for (int i = 0; i < 100; i++) begin
        div_reg = (REG_W'(i * 37 + 5) << 21) | (REG_W'(6) << 6) | REG_W'((i * 11) & 63);
        cycle();
        if (tick) cnt++;
      end
      check(cnt == 40, "R2", cnt, 40);
    end

    cur_req = "R7";
    en = 1'b0;
    for (int i = 0; i < 12; i++) begin
      cycle();
      check(tick === 1'b0, "R7", int'(tick), 0);
    end
    en = 1'b1;
    for (int i = 1; i <= 3; i++) begin
      cycle();
      check(tick === (i == 3), "R7", int'(tick), int'(i == 3));
    end

    cur_req = "R8";
    apply_field(13);
    repeat (7) cycle();
    apply_field(0);
    count_ticks(10, 10, "R8");

    cur_req = "R4";
    apply_field(32764);
    count_ticks(16384, 2, "R4");

    cur_req = "R1";
    apply_field(0);
    cycle();
    rst = 1'b1;
    cycle();
    check(tick === 1'b0, "R1", int'(tick), 0);
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule